// File: doc/BRIEF.md
# Wake-on-LAN Magic Packet Detector

This block watches a received Ethernet frame one byte at a time, as it leaves the MAC receive path, and looks for the wake-up pattern inside it. The pattern is a sync run of six 0xFF bytes. Sixteen unbroken copies of the 48-bit station address follow the sync run. Other bytes may come before and after the pattern. When the frame ends, the block combines the pattern result with the verdict of the ordinary receive address filter. If both agree, it issues a one-cycle wake-up event and sets a sticky magic-packet flag. Software clears the flag by writing 1.

A second and looser wake mode can be enabled. In that mode every frame that the address filter accepts raises the wake-up event, whether or not it holds the pattern. The magic-packet flag is left alone in that mode. CRC checking, the address filter itself and the register bus are outside this block. The filter verdict and the error flag arrive as inputs on the last byte of the frame.

Top module: `wol_magic_detect`

## Requirements
- R1: After a synchronous active-low reset, `wake_evt` and `magic_flag` are both 0.
- R2: A frame holds the pattern when it contains six 0xFF bytes followed by 16 copies of `station_addr`, each copy sent most significant byte first (bits 47:40 first). Such a frame, received with `magic_en`=1, `filt_pass`=1 and `rx_err`=0 on its last beat, makes `wake_evt` 1 for exactly the cycle after that beat. In the same cycle `magic_flag` becomes 1.
- R3: When `filt_pass` is 0 on the last beat, the frame produces no wake event and leaves `magic_flag` unchanged, even if it holds the pattern.
- R4: When `magic_en` is 0 on the last beat (and `any_wake_en` is 0), a frame holding the pattern produces no wake event and does not set `magic_flag`.
- R5: Arbitrary bytes may precede and follow the pattern. A sync run longer than six 0xFF bytes is accepted. After a mismatch, the search restarts. A mismatching 0xFF byte counts as the first byte of a new sync run.
- R6: A frame that ends before the 16th address copy is complete produces no wake event. So does a frame flagged with `rx_err`=1 on its last beat.
- R7: `magic_flag` stays 1 until a cycle with `magic_clr`=1. In the cycle after that write it reads 0, provided no new detection occurred in the write cycle.
- R8: When a detection and a `magic_clr` write fall on the same cycle, `magic_flag` is 1 afterwards.
- R9: With `any_wake_en`=1, every frame with `filt_pass`=1 and `rx_err`=0 on its last beat raises `wake_evt` the cycle after that beat. `magic_flag` is not changed by such a frame unless the frame also qualifies under R2.
- R10: A beat with `rx_sof`=1 starts a fresh search. A partial pattern from before that beat never completes a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A received byte is present on `rx_data` |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | With `rx_valid`: first byte of a frame |
| rx_eof | input | 1 | With `rx_valid`: last byte of a frame |
| rx_err | input | 1 | Frame error, sampled on the last beat |
| filt_pass | input | 1 | Address filter accepted the frame, sampled on the last beat |
| station_addr | input | 48 | Station address; bits 47:40 are sent first |
| magic_en | input | 1 | Enables magic-packet detection |
| any_wake_en | input | 1 | Enables wake on any frame the filter accepts |
| magic_clr | input | 1 | Write-1-to-clear strobe for `magic_flag` |
| wake_evt | output | 1 | One-cycle wake-up interrupt event |
| magic_flag | output | 1 | Sticky magic-packet status |

## Verification
The hardest cases to reach from the ports are the restart paths inside the matcher. One is a 0xFF byte that breaks a half-finished run of address copies and has to seed a new sync run. Another is a sync run longer than six bytes. The bench builds frames for these cases byte by byte, then lets a behavioural search over the whole stored frame decide the expected result. A second hard case is the same-cycle race between a detection and a clear write. The bench puts the clear strobe on the exact last beat of a matching frame to create it.

// File: rtl/wol_pkg.sv
// Package: shared types for the wake-on-LAN magic pattern detector.
// Assumes: nothing beyond IEEE 1800-2017.
package wol_pkg;
    // Search phase of the pattern matcher.
    typedef enum logic [1:0] {
        PH_SYNC = 2'd0,   // counting 0xFF sync bytes
        PH_ADDR = 2'd1,   // comparing address copies
        PH_DONE = 2'd2    // full pattern seen in this frame
    } match_phase_t;

    localparam logic [7:0] SYNC_BYTE = 8'hFF;
endpackage

// File: rtl/wol_seq_match.sv
// Module: wol_seq_match
// Scans a byte stream for SYNC_LEN sync bytes followed by REPEATS copies
// of an ADDR_BYTES-byte address, sent most significant byte first.
// found_now reports, on a beat, that the pattern is complete once that
// beat is included. Assumes the address has no 0xFF byte in its first
// position when long sync runs must be told apart (the address wins).
module wol_seq_match
    import wol_pkg::*;
#(
    parameter int SYNC_LEN   = 6,
    parameter int REPEATS    = 16,
    parameter int ADDR_BYTES = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    beat,
    input  logic                    sof,
    input  logic                    eof,
    input  logic [7:0]              data,
    input  logic [ADDR_BYTES*8-1:0] addr,
    output logic                    found_now
);
    localparam int SW = $clog2(SYNC_LEN + 1);
    localparam int RW = (REPEATS > 1) ? $clog2(REPEATS) : 1;
    localparam int BW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam logic [SW-1:0] SYNC_FULL = SW'(SYNC_LEN);
    localparam logic [RW-1:0] REP_LAST  = RW'(REPEATS - 1);
    localparam logic [BW-1:0] IDX_LAST  = BW'(ADDR_BYTES - 1);

    match_phase_t    ph_q, ph_b, ph_n;
    logic [SW-1:0]   ff_q, ff_b, ff_n;
    logic [RW-1:0]   rep_q, rep_b, rep_n;
    logic [BW-1:0]   idx_q, idx_b, idx_n;
    logic [7:0]      addr_b [ADDR_BYTES];
    logic            addr_hit;

    // Split the address into bytes in transmission order.
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr_byte
        assign addr_b[g] = addr[ADDR_BYTES*8-1-8*g -: 8];
    end

    // Base state for this beat: a start-of-frame beat discards history.
    always_comb begin
        if (sof) begin
            ph_b  = PH_SYNC;
            ff_b  = '0;
            rep_b = '0;
            idx_b = '0;
        end else begin
            ph_b  = ph_q;
            ff_b  = ff_q;
            rep_b = rep_q;
            idx_b = idx_q;
        end
    end

    // Is the incoming byte the next expected address byte?
    always_comb begin
        addr_hit = ((ph_b == PH_ADDR) || (ph_b == PH_SYNC && ff_b == SYNC_FULL))
                   && (data == addr_b[idx_b]);
    end

    // Next-state rule: advance on a match, otherwise restart the search.
    always_comb begin
        ph_n  = ph_b;
        ff_n  = ff_b;
        rep_n = rep_b;
        idx_n = idx_b;
        if (ph_b == PH_DONE) begin
            ph_n = PH_DONE;
        end else if (addr_hit) begin
            ph_n = PH_ADDR;
            if (idx_b == IDX_LAST) begin
                idx_n = '0;
                if (rep_b == REP_LAST) ph_n = PH_DONE;
                else rep_n = rep_b + 1'b1;
            end else begin
                idx_n = idx_b + 1'b1;
            end
        end else if (data == SYNC_BYTE) begin
            ph_n  = PH_SYNC;
            rep_n = '0;
            idx_n = '0;
            if (ph_b != PH_SYNC) ff_n = SW'(1);
            else if (ff_b < SYNC_FULL) ff_n = ff_b + 1'b1;
            else ff_n = SYNC_FULL;
        end else begin
            ph_n  = PH_SYNC;
            ff_n  = '0;
            rep_n = '0;
            idx_n = '0;
        end
    end

    assign found_now = beat && (ph_n == PH_DONE);

    // Matcher state register; cleared at reset and after each last beat.
    always_ff @(posedge clk) begin
        if (!rst_n || (beat && eof)) begin
            ph_q  <= PH_SYNC;
            ff_q  <= '0;
            rep_q <= '0;
            idx_q <= '0;
        end else if (beat) begin
            ph_q  <= ph_n;
            ff_q  <= ff_n;
            rep_q <= rep_n;
            idx_q <= idx_n;
        end
    end

    // R5: the sync counter never runs past its saturation value.
    p_sync_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ff_q <= SYNC_FULL);

    // R10: one beat after a start-of-frame beat cannot leave a finished match.
    p_sof_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && sof) |=> (ph_q != PH_DONE));

    // R2: a finished match is kept for the rest of the frame.
    p_done_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_DONE && !(beat && (sof || eof))) |=> (ph_q == PH_DONE));
endmodule

// File: rtl/wol_wake_status.sv
// Module: wol_wake_status
// Qualifies the matcher result at the last beat of a frame with the
// filter verdict, the error flag and the mode enables. Produces a
// one-cycle wake event and a sticky write-1-to-clear magic flag.
// Assumes filt_pass and err are valid on the last beat.
module wol_wake_status (
    input  logic clk,
    input  logic rst_n,
    input  logic beat,
    input  logic eof,
    input  logic err,
    input  logic filt_pass,
    input  logic magic_en,
    input  logic any_en,
    input  logic found_now,
    input  logic clr,
    output logic wake_evt,
    output logic magic_flag
);
    logic frame_ok;
    logic magic_hit;

    // Frame accepted: last beat, clean, and passed the address filter.
    always_comb begin
        frame_ok  = beat && eof && !err && filt_pass;
        magic_hit = frame_ok && magic_en && found_now;
    end

    // Wake pulse register and sticky flag; a new detection beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_evt   <= 1'b0;
            magic_flag <= 1'b0;
        end else begin
            wake_evt <= magic_hit || (frame_ok && any_en);
            if (magic_hit) magic_flag <= 1'b1;
            else if (clr)  magic_flag <= 1'b0;
        end
    end

    // R6: a wake event only follows a clean last beat.
    p_wake_eof_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |-> $past(beat && eof && !err));

    // R3: a wake event needs the filter verdict.
    p_wake_filter_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |-> $past(filt_pass));

    // R7: the flag holds while no clear arrives.
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (magic_flag && !clr) |=> magic_flag);

    // R7: a clear without a detection empties the flag.
    p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !magic_hit) |=> !magic_flag);

    // R8: a detection always leaves the flag set, clear or not.
    p_hit_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        magic_hit |=> magic_flag);

    // R4: the flag only rises while magic detection is enabled.
    p_flag_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(magic_flag) |-> $past(magic_en));
endmodule

// File: rtl/wol_magic_detect.sv
// Module: wol_magic_detect (top)
// Wake-on-LAN magic pattern detector on a received byte stream. A
// matcher finds the pattern; a status stage qualifies it with the
// filter verdict at the last beat and keeps the sticky flag.
// Assumes one byte per rx_valid beat and sof/eof aligned to beats.
module wol_magic_detect #(
    parameter int SYNC_LEN   = 6,
    parameter int REPEATS    = 16,
    parameter int ADDR_BYTES = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_valid,
    input  logic [7:0]              rx_data,
    input  logic                    rx_sof,
    input  logic                    rx_eof,
    input  logic                    rx_err,
    input  logic                    filt_pass,
    input  logic [ADDR_BYTES*8-1:0] station_addr,
    input  logic                    magic_en,
    input  logic                    any_wake_en,
    input  logic                    magic_clr,
    output logic                    wake_evt,
    output logic                    magic_flag
);
    logic found_now;

    wol_seq_match #(
        .SYNC_LEN  (SYNC_LEN),
        .REPEATS   (REPEATS),
        .ADDR_BYTES(ADDR_BYTES)
    ) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat     (rx_valid),
        .sof      (rx_sof),
        .eof      (rx_eof),
        .data     (rx_data),
        .addr     (station_addr),
        .found_now(found_now)
    );

    wol_wake_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat      (rx_valid),
        .eof       (rx_eof),
        .err       (rx_err),
        .filt_pass (filt_pass),
        .magic_en  (magic_en),
        .any_en    (any_wake_en),
        .found_now (found_now),
        .clr       (magic_clr),
        .wake_evt  (wake_evt),
        .magic_flag(magic_flag)
    );

    // R9: a wake event without magic mode needs the any-frame mode.
    p_any_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_evt && !$past(magic_en)) |-> $past(any_wake_en));
endmodule

// File: tb/wol_magic_detect_tb.sv
`timescale 1ns/1ps
module wol_magic_detect_tb;
    typedef byte unsigned bq_t[$];

    localparam logic [47:0] ADDR = 48'h3A5C7E9102B4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_sof = 1'b0;
    logic        rx_eof = 1'b0;
    logic        rx_err = 1'b0;
    logic        filt_pass = 1'b0;
    logic        magic_en = 1'b0;
    logic        any_wake_en = 1'b0;
    logic        magic_clr = 1'b0;
    logic        wake_evt;
    logic        magic_flag;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    wol_magic_detect u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
        .filt_pass(filt_pass), .station_addr(ADDR), .magic_en(magic_en),
        .any_wake_en(any_wake_en), .magic_clr(magic_clr),
        .wake_evt(wake_evt), .magic_flag(magic_flag)
    );

    // Behavioural reference: store the frame, search it whole at its end.
    bq_t frame_q;
    bit  exp_wake = 1'b0;
    bit  exp_flag = 1'b0;

    function automatic bit has_pattern(bq_t f);
        for (int i = 0; i + 6 + 96 <= f.size(); i++) begin
            bit ok = 1'b1;
            for (int k = 0; k < 6; k++)
                if (f[i+k] != 8'hFF) ok = 1'b0;
            for (int k = 0; k < 96; k++)
                if (f[i+6+k] != ADDR[47-8*(k%6) -: 8]) ok = 1'b0;
            if (ok) return 1'b1;
        end
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        bit hit, wk, acc, m;
        hit = 1'b0;
        wk  = 1'b0;
        if (!rst_n) begin
            frame_q.delete();
            exp_wake <= 1'b0;
            exp_flag <= 1'b0;
        end else begin
            if (rx_valid) begin
                if (rx_sof) frame_q.delete();
                frame_q.push_back(rx_data);
                if (rx_eof) begin
                    acc = filt_pass && !rx_err;
                    m   = magic_en && has_pattern(frame_q);
                    hit = acc && m;
                    wk  = acc && (m || any_wake_en);
                    frame_q.delete();
                end
            end
            exp_wake <= wk;
            if (hit) exp_flag <= 1'b1;
            else if (magic_clr) exp_flag <= 1'b0;
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            n_checks++;
            if (wake_evt !== exp_wake) begin
                n_fail++;
                $display("FAIL %s wake_evt act=%b exp=%b t=%0t", cur_req, wake_evt, exp_wake, $time);
            end
            n_checks++;
            if (magic_flag !== exp_flag) begin
                n_fail++;
                $display("FAIL %s magic_flag act=%b exp=%b t=%0t", cur_req, magic_flag, exp_flag, $time);
            end
        end
    end

    function automatic bq_t mk(int pre, int ffn, int reps, int post);
        bq_t f;
        for (int i = 0; i < pre; i++) f.push_back(8'(8'h10 + i));
        for (int i = 0; i < ffn; i++) f.push_back(8'hFF);
        for (int r = 0; r < reps; r++)
            for (int k = 0; k < 6; k++) f.push_back(ADDR[47-8*k -: 8]);
        for (int i = 0; i < post; i++) f.push_back(8'(8'h20 + i));
        return f;
    endfunction

    task automatic send(bq_t f, bit fp, bit er, bit clr_last);
        for (int i = 0; i < f.size(); i++) begin
            @(negedge clk);
            rx_valid  = 1'b1;
            rx_data   = f[i];
            rx_sof    = (i == 0);
            rx_eof    = (i == f.size() - 1);
            filt_pass = fp;
            rx_err    = er;
            magic_clr = clr_last && (i == f.size() - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        rx_err = 1'b0; magic_clr = 1'b0; filt_pass = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_flag();
        @(negedge clk); magic_clr = 1'b1;
        @(negedge clk); magic_clr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog act=timeout exp=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        bq_t f, g;
        repeat (3) @(negedge clk);
        cmp_on = 1'b1;                          // R1: outputs checked in reset
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);              // R1: idle after reset

        cur_req = "R2";  magic_en = 1'b1;
        send(mk(0, 6, 16, 4), 1'b1, 1'b0, 1'b0);

        cur_req = "R7";  clear_flag();

        cur_req = "R5";  send(mk(14, 6, 16, 9), 1'b1, 1'b0, 1'b0);
        clear_flag();
        cur_req = "R5";  send(mk(3, 9, 16, 2), 1'b1, 1'b0, 1'b0);   // long sync run
        clear_flag();
        // Partial copies broken by 0xFF bytes, then a full pattern.
        f = mk(2, 6, 3, 0);
        f.push_back(8'hFF);
        g = mk(0, 5, 16, 3);
        foreach (g[i]) f.push_back(g[i]);
        cur_req = "R5";  send(f, 1'b1, 1'b0, 1'b0);
        clear_flag();

        cur_req = "R3";  send(mk(1, 6, 16, 1), 1'b0, 1'b0, 1'b0);
        cur_req = "R4";  magic_en = 1'b0;
        send(mk(1, 6, 16, 1), 1'b1, 1'b0, 1'b0);
        magic_en = 1'b1;
        cur_req = "R6";  send(mk(1, 6, 15, 0), 1'b1, 1'b0, 1'b0);
        cur_req = "R6";  send(mk(1, 6, 16, 2), 1'b1, 1'b1, 1'b0);

        cur_req = "R8";  send(mk(0, 6, 16, 1), 1'b1, 1'b0, 1'b1);
        cur_req = "R7";  clear_flag();

        cur_req = "R9";  any_wake_en = 1'b1; magic_en = 1'b0;
        send(mk(8, 0, 0, 5), 1'b1, 1'b0, 1'b0);
        send(mk(8, 0, 0, 5), 1'b0, 1'b0, 1'b0);
        send(mk(0, 6, 16, 0), 1'b1, 1'b0, 1'b0);
        any_wake_en = 1'b0; magic_en = 1'b1;

        // R10: first half in one frame, rest after a new start of frame.
        cur_req = "R10";
        f = mk(0, 6, 8, 0);
        for (int i = 0; i < f.size(); i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = f[i]; rx_sof = (i == 0); rx_eof = 1'b0;
        end
        send(mk(0, 0, 8, 1), 1'b1, 1'b0, 1'b0);

        cur_req = "R2";  send(mk(5, 7, 16, 5), 1'b1, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule